// File: doc/BRIEF.md
# Video Clamp and Gain Controller

This block is the digital half of a black-level and amplitude control loop for a three-channel video digitiser. Each channel delivers an 8-bit sample per clock. For each channel, the block averages the samples that fall inside a programmable window near the start of every line. It compares that average with the channel's black target and nudges a signed clamp correction word toward it by at most one step per line. Channels carrying luma or composite video aim at code 64. Chroma channels aim at code 128.

Every channel has a static gain word that is loaded through a small register port. Channel 0 can instead take its gain from an automatic loop that follows the peak of each line. The loop backs off when the converter is driven to the top of its range, and it raises the gain while the line peak stays under a programmed target. A line counter, restarted by the rising edge of the vertical sync input, produces a vertical blanking pulse with programmable first and stop lines. While that pulse is active, clamp and gain updates are held. A mode bit can hand this hold over to the vertical sync input directly, treated as active high.

The surrounding amplifier and converter consume the correction and gain words. The block itself only measures, decides and holds.

Top module: `vclamp_gain_ctrl`

## Requirements
- R1: A synchronous active-low reset sets every gain output to mid-scale (128), every clamp correction to 0, drives the blanking output low, and loads the register defaults: window start 4, window size code 2, blanking lines 0/0, peak target 192, control 0.
- R2: At each line strobe, for each channel whose window was filled on the line just ended, the correction decreases by one if the window average is above the target, increases by one if it is below, and holds if it is equal. The target is 64 for channel 0 (luma/composite) and 128 for channels 1 and 2 (chroma).
- R3: The window covers sample indices start .. start + 2^size - 1, where the sample presented with the line strobe is index 0, start is register 3 and size is register 4 bits [2:0]. The average is the window sum shifted right by size. The correction moves only at a line strobe and by at most one step.
- R4: The clamp correction is an 8-bit two's-complement word that saturates at -128 and +127 and never wraps.
- R5: A write to register address 0, 1 or 2 loads the static gain of that channel; the new value appears on the gain output from the next cycle while that channel uses its static gain.
- R6: With control bit 0 (register 8) set, channel 0's gain output comes from the automatic loop. At each line strobe it steps down by one if any channel-0 sample of the ended line reached 254 or more. Otherwise it steps up by one if the line peak was below the target (register 7). Otherwise it holds.
- R7: The automatic gain word saturates at 0 and 255 and never wraps.
- R8: The line count is cleared by a rising edge of the vertical sync input (this takes priority over a simultaneous line strobe) and otherwise advances at each line strobe. The blanking output is high while the count is at least register 5 and below register 6.
- R9: A line strobe that arrives while the blanking output is high, with control bit 1 clear, makes no change to any correction or to the automatic gain.
- R10: With control bit 1 set, updates at a line strobe are instead held whenever the vertical sync input is high in that cycle.
- R11: A channel whose window did not receive exactly 2^size samples on the ended line, or any strobe that is the first after reset, leaves that correction unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_i | input | 24 | Channel k sample at bits [8k+7:8k] |
| line_start_i | input | 1 | One-cycle strobe with sample index 0 of a line |
| vsync_i | input | 1 | Vertical sync, active high |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| clamp_corr_o | output | 24 | Signed clamp correction, channel k at [8k+7:8k] |
| gain_o | output | 24 | Gain word, channel k at [8k+7:8k] |
| vblank_o | output | 1 | Vertical blanking pulse |

## Verification
The line strobe can land in the same cycle as the rising edge of vertical sync. The decision for the ended line must then use the old line count, and the count must restart at 0 rather than 1. The bench provokes this by raising sync exactly on a strobe while blanking covers lines 1 and 2. It then checks that the strobe's update is applied, and that the following lines are held and show the blanking output high. The same collision is repeated with the sync-driven hold mode selected, where the strobe must be frozen instead.

// File: rtl/vcg_pkg.sv
// Shared register map and reset values for the clamp and gain controller.
package vcg_pkg;
    localparam int ADDR_W = 4;
    localparam int REG_W  = 8;

    // Register addresses; 0 .. N_CH-1 hold the static gains.
    localparam logic [ADDR_W-1:0] A_WIN_START = 4'd3;
    localparam logic [ADDR_W-1:0] A_WIN_LOG   = 4'd4;
    localparam logic [ADDR_W-1:0] A_VB_FIRST  = 4'd5;
    localparam logic [ADDR_W-1:0] A_VB_STOP   = 4'd6;
    localparam logic [ADDR_W-1:0] A_PEAK_TGT  = 4'd7;
    localparam logic [ADDR_W-1:0] A_CTRL      = 4'd8;

    localparam int CTRL_AGC_BIT = 0;
    localparam int CTRL_EXT_BIT = 1;

    localparam logic [REG_W-1:0] WIN_START_RST = 8'd4;
    localparam logic [2:0]       WIN_LOG_RST   = 3'd2;
    localparam logic [REG_W-1:0] PEAK_TGT_RST  = 8'd192;

    typedef struct packed {
        logic [REG_W-1:0] win_start;
        logic [2:0]       win_log;
        logic [REG_W-1:0] vb_first;
        logic [REG_W-1:0] vb_stop;
        logic [REG_W-1:0] peak_tgt;
        logic             agc_en;
        logic             ext_vs;
    } vcg_cfg_t;
endpackage

// File: rtl/vcg_regs.sv
// Register file: static gain words per channel plus window, blanking,
// peak target and mode settings. Assumes GAIN_W <= REG_W.
module vcg_regs
    import vcg_pkg::*;
#(
    parameter int N_CH   = 3,
    parameter int GAIN_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [REG_W-1:0]         wdata_i,
    output vcg_cfg_t                 cfg_o,
    output logic [N_CH*GAIN_W-1:0]   gain_st_o
);
    localparam logic [GAIN_W-1:0] GAIN_MID = {1'b1, {(GAIN_W-1){1'b0}}};

    // Static gain words, one per channel, addressed 0 .. N_CH-1.
    always_ff @(posedge clk) begin
        for (int k = 0; k < N_CH; k++) begin
            if (!rst_n)
                gain_st_o[k*GAIN_W +: GAIN_W] <= GAIN_MID;
            else if (wr_i && addr_i == ADDR_W'(k))
                gain_st_o[k*GAIN_W +: GAIN_W] <= wdata_i[GAIN_W-1:0];
        end
    end

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o.win_start <= WIN_START_RST;
            cfg_o.win_log   <= WIN_LOG_RST;
            cfg_o.vb_first  <= '0;
            cfg_o.vb_stop   <= '0;
            cfg_o.peak_tgt  <= PEAK_TGT_RST;
            cfg_o.agc_en    <= 1'b0;
            cfg_o.ext_vs    <= 1'b0;
        end else if (wr_i) begin
            case (addr_i)
                A_WIN_START: cfg_o.win_start <= wdata_i;
                A_WIN_LOG:   cfg_o.win_log   <= wdata_i[2:0];
                A_VB_FIRST:  cfg_o.vb_first  <= wdata_i;
                A_VB_STOP:   cfg_o.vb_stop   <= wdata_i;
                A_PEAK_TGT:  cfg_o.peak_tgt  <= wdata_i;
                A_CTRL: begin
                    cfg_o.agc_en <= wdata_i[CTRL_AGC_BIT];
                    cfg_o.ext_vs <= wdata_i[CTRL_EXT_BIT];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vcg_line_timing.sv
// Line and field timing: sample index within the line, clamp window flag,
// line count restarted by vertical sync, blanking pulse, and the update
// strobe that is withheld on the first line and while frozen.
// Assumes LINE_W >= 8 and PIX_W >= 8.
module vcg_line_timing #(
    parameter int PIX_W  = 11,
    parameter int LINE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_start_i,
    input  logic       vsync_i,
    input  logic [7:0] win_start_i,
    input  logic [2:0] win_log_i,
    input  logic [7:0] vb_first_i,
    input  logic [7:0] vb_stop_i,
    input  logic       ext_vs_i,
    output logic       in_win_o,
    output logic       upd_o,
    output logic       vblank_o
);
    localparam logic [PIX_W-1:0]  PIX_MAX  = '1;
    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    logic [PIX_W-1:0]  pix_cnt_q, pix_idx;
    logic [LINE_W-1:0] line_cnt_q;
    logic [PIX_W:0]    win_lo, win_hi;
    logic              vs_q, vs_rise, line_act_q, freeze;

    // Current sample index: 0 on the strobe, else the running count.
    always_comb begin
        pix_idx = line_start_i ? '0 : pix_cnt_q;
        win_lo  = (PIX_W+1)'(win_start_i);
        win_hi  = win_lo + ((PIX_W+1)'(1) << win_log_i);
        in_win_o = ({1'b0, pix_idx} >= win_lo) && ({1'b0, pix_idx} < win_hi);
    end

    // Saturating sample counter within the line.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pix_cnt_q <= '0;
        else if (pix_idx == PIX_MAX) pix_cnt_q <= pix_idx;
        else                         pix_cnt_q <= pix_idx + 1'b1;
    end

    assign vs_rise = vsync_i && !vs_q;

    // Sync edge detector, line count and first-line flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q       <= 1'b0;
            line_cnt_q <= '0;
            line_act_q <= 1'b0;
        end else begin
            vs_q <= vsync_i;
            if (vs_rise)
                line_cnt_q <= '0;
            else if (line_start_i && line_cnt_q != LINE_MAX)
                line_cnt_q <= line_cnt_q + 1'b1;
            if (line_start_i)
                line_act_q <= 1'b1;
        end
    end

    // Blanking window on the line count and the resulting hold decision.
    always_comb begin
        vblank_o = (line_cnt_q >= LINE_W'(vb_first_i)) && (line_cnt_q < LINE_W'(vb_stop_i));
        freeze   = ext_vs_i ? vsync_i : vblank_o;
        upd_o    = line_start_i && line_act_q && !freeze;
    end

    assert_line_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync_i) |=> (line_cnt_q == '0));
endmodule

// File: rtl/vcg_clamp_ch.sv
// One clamp channel: sums the samples inside the window, and at an update
// strobe compares the window average with TARGET and moves a signed
// correction by one step, saturating. A partly filled window is ignored.
// Assumes ACC_W >= DATA_W + 7 (window of up to 128 samples).
module vcg_clamp_ch #(
    parameter int DATA_W = 8,
    parameter int CORR_W = 8,
    parameter int ACC_W  = 15,
    parameter int TARGET = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     line_start_i,
    input  logic [DATA_W-1:0]        sample_i,
    input  logic                     in_win_i,
    input  logic                     upd_i,
    input  logic [2:0]               win_log_i,
    output logic signed [CORR_W-1:0] corr_o
);
    localparam logic signed [CORR_W-1:0] CMAX = {1'b0, {(CORR_W-1){1'b1}}};
    localparam logic signed [CORR_W-1:0] CMIN = {1'b1, {(CORR_W-1){1'b0}}};
    localparam logic [CORR_W-1:0]        ONE  = 1;
    localparam logic [DATA_W-1:0]        TGT  = DATA_W'(TARGET);

    logic [ACC_W-1:0]  acc_q;
    logic [7:0]        cnt_q, need;
    logic [DATA_W-1:0] avg;
    logic              full;

    // Window fill check and average of the ended line.
    always_comb begin
        need = 8'd1 << win_log_i;
        full = (cnt_q == need);
        avg  = DATA_W'(acc_q >> win_log_i);
    end

    // Window accumulator, restarted with the first sample of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (line_start_i) begin
            acc_q <= in_win_i ? ACC_W'(sample_i) : '0;
            cnt_q <= in_win_i ? 8'd1 : 8'd0;
        end else if (in_win_i && cnt_q != 8'hFF) begin
            acc_q <= acc_q + ACC_W'(sample_i);
            cnt_q <= cnt_q + 8'd1;
        end
    end

    // One-step saturating correction toward the target.
    always_ff @(posedge clk) begin
        if (!rst_n)
            corr_o <= '0;
        else if (upd_i && full) begin
            if (avg > TGT && corr_o != CMIN)      corr_o <= corr_o - 1'b1;
            else if (avg < TGT && corr_o != CMAX) corr_o <= corr_o + 1'b1;
        end
    end

    assert_quiet_between_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start_i |=> $stable(corr_o));
    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((corr_o - $past(corr_o)) == '0) || ((corr_o - $past(corr_o)) == ONE)
        || (($past(corr_o) - corr_o) == ONE));
    assert_frozen_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start_i && !upd_i) |=> $stable(corr_o));
    assert_no_wrap_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_o == CMAX) |=> (corr_o != CMIN));
    assert_no_wrap_bottom_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_o == CMIN) |=> (corr_o != CMAX));
endmodule

// File: rtl/vcg_agc.sv
// Automatic gain loop for one channel: tracks the line peak and an
// overload flag, then at an update strobe steps the gain down on overload
// or up when the peak is under target. Saturates; resets to mid-scale.
module vcg_agc #(
    parameter int DATA_W   = 8,
    parameter int GAIN_W   = 8,
    parameter int OVF_CODE = 254
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start_i,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              upd_i,
    input  logic              en_i,
    input  logic [DATA_W-1:0] target_i,
    output logic [GAIN_W-1:0] gain_o
);
    localparam logic [GAIN_W-1:0] GMAX     = '1;
    localparam logic [GAIN_W-1:0] GAIN_MID = {1'b1, {(GAIN_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] OVF      = DATA_W'(OVF_CODE);

    logic [DATA_W-1:0] peak_q;
    logic              ovf_q;

    // Peak and overload tracking, restarted with each line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak_q <= '0;
            ovf_q  <= 1'b0;
        end else if (line_start_i) begin
            peak_q <= sample_i;
            ovf_q  <= (sample_i >= OVF);
        end else begin
            if (sample_i > peak_q) peak_q <= sample_i;
            if (sample_i >= OVF)   ovf_q  <= 1'b1;
        end
    end

    // Saturating one-step gain adjustment per line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gain_o <= GAIN_MID;
        else if (upd_i && en_i) begin
            if (ovf_q) begin
                if (gain_o != '0) gain_o <= gain_o - 1'b1;
            end else if (peak_q < target_i && gain_o != GMAX)
                gain_o <= gain_o + 1'b1;
        end
    end

    assert_agc_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start_i |=> $stable(gain_o));
    assert_gain_no_wrap_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_o == GMAX) |=> (gain_o != '0));
    assert_gain_no_wrap_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_o == '0) |=> (gain_o != GMAX));
endmodule

// File: rtl/vclamp_gain_ctrl.sv
// Top: clamp and gain control for N_CH video channels. Channel kinds are
// set by CHROMA_MASK (bit set = chroma target). Channel AGC_CH may use the
// automatic gain loop. Assumes DATA_W = 8 and GAIN_W <= 8.
module vclamp_gain_ctrl
    import vcg_pkg::*;
#(
    parameter int              N_CH        = 3,
    parameter int              DATA_W      = 8,
    parameter int              GAIN_W      = 8,
    parameter int              CORR_W      = 8,
    parameter int              PIX_W       = 11,
    parameter int              LINE_W      = 10,
    parameter logic [N_CH-1:0] CHROMA_MASK = 3'b110,
    parameter int              LUMA_CODE   = 64,
    parameter int              CHROMA_CODE = 128,
    parameter int              AGC_CH      = 0,
    parameter int              OVF_CODE    = 254
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_CH*DATA_W-1:0]   sample_i,
    input  logic                     line_start_i,
    input  logic                     vsync_i,
    input  logic                     reg_wr_i,
    input  logic [ADDR_W-1:0]        reg_addr_i,
    input  logic [REG_W-1:0]         reg_wdata_i,
    output logic [N_CH*CORR_W-1:0]   clamp_corr_o,
    output logic [N_CH*GAIN_W-1:0]   gain_o,
    output logic                     vblank_o
);
    localparam int ACC_W = DATA_W + 7;

    vcg_cfg_t                 cfg;
    logic [N_CH*GAIN_W-1:0]   gain_st;
    logic [GAIN_W-1:0]        agc_gain;
    logic                     in_win, upd;

    vcg_regs #(.N_CH(N_CH), .GAIN_W(GAIN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .cfg_o(cfg), .gain_st_o(gain_st));

    vcg_line_timing #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_timing (
        .clk(clk), .rst_n(rst_n), .line_start_i(line_start_i), .vsync_i(vsync_i),
        .win_start_i(cfg.win_start), .win_log_i(cfg.win_log),
        .vb_first_i(cfg.vb_first), .vb_stop_i(cfg.vb_stop), .ext_vs_i(cfg.ext_vs),
        .in_win_o(in_win), .upd_o(upd), .vblank_o(vblank_o));

    vcg_agc #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .OVF_CODE(OVF_CODE)) u_agc (
        .clk(clk), .rst_n(rst_n), .line_start_i(line_start_i),
        .sample_i(sample_i[AGC_CH*DATA_W +: DATA_W]), .upd_i(upd),
        .en_i(cfg.agc_en), .target_i(cfg.peak_tgt), .gain_o(agc_gain));

    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        vcg_clamp_ch #(
            .DATA_W(DATA_W), .CORR_W(CORR_W), .ACC_W(ACC_W),
            .TARGET(CHROMA_MASK[k] ? CHROMA_CODE : LUMA_CODE)
        ) u_clamp (
            .clk(clk), .rst_n(rst_n), .line_start_i(line_start_i),
            .sample_i(sample_i[k*DATA_W +: DATA_W]), .in_win_i(in_win),
            .upd_i(upd), .win_log_i(cfg.win_log),
            .corr_o(clamp_corr_o[k*CORR_W +: CORR_W]));

        if (k == AGC_CH) begin : g_auto
            // Gain source select for the channel with the automatic loop.
            assign gain_o[k*GAIN_W +: GAIN_W] =
                cfg.agc_en ? agc_gain : gain_st[k*GAIN_W +: GAIN_W];
        end else begin : g_static
            assign gain_o[k*GAIN_W +: GAIN_W] = gain_st[k*GAIN_W +: GAIN_W];
        end
    end

    assert_vblank_idle_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !vblank_o);
endmodule

// File: tb/sim_vclamp_gain_ctrl.sv
module sim_vclamp_gain_ctrl;
    localparam int LEN = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] sample_i = '0;
    logic        line_start_i = 1'b0;
    logic        vsync_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [3:0]  reg_addr_i = '0;
    logic [7:0]  reg_wdata_i = '0;
    logic [23:0] clamp_corr_o, gain_o;
    logic        vblank_o;

    always #10 clk = ~clk;

    vclamp_gain_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .line_start_i(line_start_i),
        .vsync_i(vsync_i), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .clamp_corr_o(clamp_corr_o), .gain_o(gain_o),
        .vblank_o(vblank_o));

    int checks = 0, errors = 0;

    // Reference model state
    int ecorr[3], gst[3], ag;
    int ws = 4, wl = 2, vbs = 0, vbe = 0, tgt = 192;
    bit agc_en = 0, ext_vs = 0, act = 0, vsp = 0;
    int ln = 0, pix = 0, pk = 0;
    int sum[3], cnt[3], cv[3];
    bit ov = 0, cvs = 0;

    task automatic check(string req, string what, int act_v, int exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act_v, exp_v);
        end
    endtask

    task automatic check_all(string tag);
        for (int k = 0; k < 3; k++) begin
            check(tag, $sformatf("corr%0d", k), int'($signed(clamp_corr_o[k*8 +: 8])), ecorr[k]);
            check(tag, $sformatf("gain%0d", k), int'(gain_o[k*8 +: 8]),
                  (k == 0 && agc_en) ? ag : gst[k]);
        end
        check("R8", "vblank", int'(vblank_o), int'(ln >= vbs && ln < vbe));
    endtask

    // Update of the ended line as set by R2, R4, R6, R7, R11.
    task automatic apply_line();
        for (int k = 0; k < 3; k++) begin
            if (cnt[k] == (1 << wl)) begin
                int avg = sum[k] >> wl;
                int t = (k == 0) ? 64 : 128;
                if (avg > t && ecorr[k] > -128) ecorr[k]--;
                else if (avg < t && ecorr[k] < 127) ecorr[k]++;
            end
        end
        if (agc_en) begin
            if (ov) begin
                if (ag > 0) ag--;
            end else if (pk < tgt && ag < 255) ag++;
        end
    endtask

    // One clock: drive at the negedge, advance the model, wait a cycle.
    task automatic tick(bit ls, int v0, int v1, int v2, bit vs, bit w, int a, int d);
        int idx = ls ? 0 : pix;
        bit rise = vs && !vsp;
        bit inw;
        int v[3];
        v[0] = v0; v[1] = v1; v[2] = v2;
        if (ls) begin
            bit frozen = ext_vs ? vs : (ln >= vbs && ln < vbe);
            if (act && !frozen) apply_line();
            act = 1;
        end
        if (rise) ln = 0;
        else if (ls) ln++;
        inw = (idx >= ws) && (idx < ws + (1 << wl));
        for (int k = 0; k < 3; k++) begin
            if (ls) begin
                sum[k] = inw ? v[k] : 0;
                cnt[k] = inw ? 1 : 0;
            end else if (inw) begin
                sum[k] += v[k];
                cnt[k]++;
            end
        end
        if (ls) begin
            pk = v0; ov = (v0 >= 254);
        end else begin
            if (v0 > pk) pk = v0;
            if (v0 >= 254) ov = 1;
        end
        pix = (idx < 2047) ? idx + 1 : 2047;
        if (w) begin
            case (a)
                0, 1, 2: gst[a] = d;
                3: ws = d;
                4: wl = d % 8;
                5: vbs = d;
                6: vbe = d;
                7: tgt = d;
                8: begin agc_en = d[0]; ext_vs = d[1]; end
                default: ;
            endcase
        end
        vsp = vs;
        cv = v; cvs = vs;
        line_start_i = ls;
        sample_i = {v2[7:0], v1[7:0], v0[7:0]};
        vsync_i = vs;
        reg_wr_i = w;
        reg_addr_i = a[3:0];
        reg_wdata_i = d[7:0];
        @(negedge clk);
        line_start_i = 1'b0;
        reg_wr_i = 1'b0;
    endtask

    task automatic wr(int a, int d);
        tick(0, cv[0], cv[1], cv[2], cvs, 1, a, d);
    endtask

    task automatic set_vs(bit vs);
        tick(0, cv[0], cv[1], cv[2], vs, 0, 0, 0);
    endtask

    function automatic int smp(int base, int i);
        return base + ((i * 5) % 7) - 3;
    endfunction

    // One line; channel 0 carries value p at index pp; optional sync edge on the strobe.
    task automatic run_line(int b0, int b1, int b2, int p, int pp, bit vs_at_start, string tag);
        for (int i = 0; i < LEN; i++) begin
            bit vs = vs_at_start ? (i == 0) : cvs;
            tick(i == 0, (i == pp) ? p : smp(b0, i), smp(b1, i), smp(b2, i), vs, 0, 0, 0);
            if (i == 0) check_all(tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 3; k++) begin
            ecorr[k] = 0; gst[k] = 128; sum[k] = 0; cnt[k] = 0; cv[k] = 0;
        end
        ag = 128;
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;

        // R5: static gain writes
        wr(1, 8'h37); check_all("R5");
        wr(2, 8'hC8); check_all("R5");
        wr(0, 8'h50); check_all("R5");

        // R11: first strobe after reset, then R2 direction and hold
        run_line(80, 100, 128, 0, 99, 0, "R11");
        for (int n = 0; n < 6; n++) run_line(80, 100, 128, 0, 99, 0, "R2");
        for (int n = 0; n < 3; n++) run_line(64, 128, 200, 0, 99, 0, "R2");
        for (int n = 0; n < 3; n++) run_line(30, 160, 20, 0, 99, 0, "R2");

        // R3: wider window at a new position, with an outlier inside it
        wr(3, 9); wr(4, 3);
        for (int n = 0; n < 4; n++) run_line(66, 126, 131, 250, 12, 0, "R3");
        for (int n = 0; n < 4; n++) run_line(62, 129, 127, 3, 10, 0, "R3");
        wr(3, 4); wr(4, 2);

        // R4: drive corrections into both rails
        for (int n = 0; n < 140; n++) run_line(250, 10, 250, 0, 99, 0, "R4");
        for (int n = 0; n < 3; n++) run_line(250, 10, 250, 0, 99, 0, "R4");

        // R11: window runs past the line end
        wr(3, 30);
        for (int n = 0; n < 4; n++) run_line(10, 250, 10, 0, 99, 0, "R11");
        wr(3, 4);

        // R6/R7: automatic gain on channel 0
        wr(8, 1); check_all("R6");
        for (int n = 0; n < 135; n++) run_line(60, 128, 128, 150, 20, 0, "R7");
        wr(7, 200);
        for (int n = 0; n < 3; n++) run_line(60, 128, 128, 220, 20, 0, "R6");
        for (int n = 0; n < 260; n++) run_line(60, 128, 128, 254, 20, 0, "R7");
        for (int n = 0; n < 4; n++) run_line(60, 128, 128, 120, 7, 0, "R6");

        // R8/R9: internal blanking on lines 1 and 2
        wr(5, 1); wr(6, 3);
        set_vs(1); set_vs(0); check_all("R8");
        for (int n = 0; n < 5; n++) run_line(200, 40, 200, 100, 20, 0, "R9");
        // Sync edge on the strobe itself
        run_line(20, 200, 20, 100, 20, 1, "R9");
        for (int n = 0; n < 4; n++) run_line(20, 200, 20, 100, 20, 0, "R9");

        // R10: hold follows the sync input level
        wr(5, 0); wr(6, 0); wr(8, 3);
        set_vs(1);
        for (int n = 0; n < 3; n++) run_line(150, 60, 150, 100, 20, 0, "R10");
        set_vs(0);
        for (int n = 0; n < 3; n++) run_line(150, 60, 150, 100, 20, 0, "R10");
        run_line(150, 60, 150, 100, 20, 1, "R10");
        run_line(150, 60, 150, 100, 20, 0, "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule